// File: doc/BRIEF.md
# Reversible Carry-Ancilla Incrementer Sequencer

This block adds one to an N-bit word. It does not use a carry-lookahead adder. It holds the word next to N-1 auxiliary carry bits in one working vector. It then applies a fixed schedule of reversible gates to that vector, one gate per clock. Each gate is NOT, controlled-NOT (target ^= control) or two-control Toffoli (target ^= a & b). The schedule first builds the carry chain upward from the least significant bit. It then writes each carry into its data bit, working from the most significant end down, and clears each carry in mirror order once its consumer no longer needs it. The run ends with an unconditional inversion of bit 0.

A word enters on a valid/ready handshake together with a mode bit. With the mode bit high, every carry is cleared before the run ends. With it low, the clearing Toffolis on the upper carries are left out of the schedule. The run is then shorter, and those carries end holding their computed values. The data result is the same in both modes. The result leaves on a second valid/ready handshake. A producer may hold `in_valid` high at any time, because the block takes nothing while it is busy or holding a result. A consumer may stall by keeping `out_ready` low for as long as it likes. The result is held until it is taken.

Top module: `carry_ancilla_incr`

## Requirements
- R1: `in_ready` is high exactly when the block is idle, and a word is taken only on a clock edge where `in_valid` and `in_ready` are both high. A word offered while `in_ready` is low is ignored, and its value never reaches a result.
- R2: The presented `out_value` equals the accepted word plus one, modulo 2^N, in both modes.
- R3: An all-ones input produces all zeros. No carry-out bit exists.
- R4: With `in_keep_clean` = 1 at acceptance, every bit of `out_carries` is 0 and `out_clean` is 1 when `out_valid` is high.
- R5: With `in_keep_clean` = 0, `out_carries[0]` is 0 and `out_carries[k]` (k ≥ 1) equals the AND of input bits 0..k. `out_clean` is low exactly when input bits 0 and 1 are both 1.
- R6: `out_valid` first rises 3N-2 clock edges after the accepting edge in mode 1, and 2N edges after it in mode 0. For N = 4, these are 10 and 8 gate steps.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_value`, `out_carries` and `out_clean` stay stable. `out_valid` drops on the edge where `out_ready` is high, and the block then becomes idle.
- R8: Each gate step changes at most one bit of the working vector {`out_carries`, `out_value`}. A step's target is never one of its own controls.
- R9: After reset, `in_ready` is 1, `out_valid` is 0, and `out_value` and `out_carries` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Block is idle and takes the offered word |
| in_value | input | WIDTH | Word to increment |
| in_keep_clean | input | 1 | 1: clear all carries before finishing; 0: leave the upper carries set |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | WIDTH | Incremented word (working data bits while a run is in progress) |
| out_carries | output | WIDTH-1 | Final carry bits; bit k is carry k |
| out_clean | output | 1 | All carry bits are zero |

## Verification
The hardest condition to reach from the ports is a word offered while the block is busy or stalled on output, followed by a check that this word never leaks into a result. The stimulus keeps `in_valid` high with a deliberately wrong value for several cycles after each acceptance, and it throttles `out_ready` on an irregular pattern so that results wait in the holding state. The carry-residue rule of the no-clear mode needs inputs whose low bits are all ones, so every input value is sent in both modes. The single-bit-per-step rule is observed on the working vector, which appears on the outputs while a run is in progress.

// File: rtl/rinc_pkg.sv
package rinc_pkg;

  localparam int IDXW = 8;

  typedef enum logic [1:0] {
    GATE_NONE,
    GATE_NOT,
    GATE_CNOT,
    GATE_TOFF
  } gate_kind_e;

  typedef struct packed {
    gate_kind_e      kind;
    logic [IDXW-1:0] tgt;
    logic [IDXW-1:0] ctl_a;
    logic [IDXW-1:0] ctl_b;
  } gate_op_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_HOLD
  } seq_state_e;

  function automatic int run_length(input int n, input logic clean);
    return clean ? (3 * n - 2) : (2 * n);
  endfunction

  function automatic gate_op_t make_op(input gate_kind_e k, input int t,
                                       input int a, input int b);
    gate_op_t o;
    o.kind  = k;
    o.tgt   = IDXW'(t);
    o.ctl_a = IDXW'(a);
    o.ctl_b = IDXW'(b);
    return o;
  endfunction

endpackage

// File: rtl/rinc_schedule.sv
module rinc_schedule
  import rinc_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int STEPW = 4
) (
  input  logic [STEPW-1:0] step,
  input  logic             keep_clean,
  input  logic             active,
  output gate_op_t         op,
  output logic             last
);

  // working vector layout: data bit i at index i, carry k at index WIDTH+k
  localparam int CBASE = WIDTH;

  int pos;
  int len;
  int q;
  int lane;

  always_comb begin
    pos  = int'(step);
    len  = run_length(WIDTH, keep_clean);
    q    = pos - WIDTH;
    lane = 0;
    op   = make_op(GATE_NONE, 0, 0, 0);
    if (pos == 0) begin
      // first carry from bit 0
      op = make_op(GATE_CNOT, CBASE, 0, 0);
    end else if (pos <= WIDTH - 2) begin
      // carry chain upward
      op = make_op(GATE_TOFF, CBASE + pos, CBASE + pos - 1, pos);
    end else if (pos == WIDTH - 1) begin
      // top data bit takes the top carry
      op = make_op(GATE_CNOT, WIDTH - 1, CBASE + WIDTH - 2, CBASE + WIDTH - 2);
    end else if (pos == len - 2) begin
      // clear carry 0 while bit 0 is still original
      op = make_op(GATE_CNOT, CBASE, 0, 0);
    end else if (pos == len - 1) begin
      op = make_op(GATE_NOT, 0, CBASE, CBASE);
    end else if (keep_clean) begin
      // pairs: uncompute carry(lane), then bit(lane) ^= carry(lane-1)
      lane = WIDTH - 2 - (q >> 1);
      if ((q & 1) == 0)
        op = make_op(GATE_TOFF, CBASE + lane, CBASE + lane - 1, lane);
      else
        op = make_op(GATE_CNOT, lane, CBASE + lane - 1, CBASE + lane - 1);
    end else begin
      lane = WIDTH - 2 - q;
      op = make_op(GATE_CNOT, lane, CBASE + lane - 1, CBASE + lane - 1);
    end
    last = (pos == len - 1);
  end

  // the step counter never runs past the schedule
  always_comb begin
    if (active) begin
      assert_step_in_range_R6: assert (pos < len)
        else $error("schedule step %0d beyond length %0d", pos, len);
    end
  end

endmodule

// File: rtl/rinc_gate.sv
module rinc_gate
  import rinc_pkg::*;
#(
  parameter int SBITS = 7
) (
  input  logic             apply,
  input  gate_op_t         op,
  input  logic [SBITS-1:0] cur,
  output logic [SBITS-1:0] nxt
);

  logic [SBITS-1:0] hit_t;
  logic [SBITS-1:0] hit_a;
  logic [SBITS-1:0] hit_b;
  logic             val_a;
  logic             val_b;
  logic             fire;

  for (genvar g = 0; g < SBITS; g++) begin : g_dec
    assign hit_t[g] = (op.tgt   == IDXW'(g));
    assign hit_a[g] = (op.ctl_a == IDXW'(g));
    assign hit_b[g] = (op.ctl_b == IDXW'(g));
  end

  assign val_a = |(cur & hit_a);
  assign val_b = |(cur & hit_b);

  always_comb begin
    unique case (op.kind)
      GATE_NOT:  fire = 1'b1;
      GATE_CNOT: fire = val_a;
      GATE_TOFF: fire = val_a & val_b;
      default:   fire = 1'b0;
    endcase
  end

  assign nxt = cur ^ (hit_t & {SBITS{apply & fire}});

  // reversibility: a gate never writes a bit it reads
  always_comb begin
    if (apply && (op.kind == GATE_CNOT || op.kind == GATE_TOFF)) begin
      assert_ctl_distinct_R8: assert ((hit_t & (hit_a | hit_b)) == '0)
        else $error("gate target overlaps a control");
    end
    if (apply && op.kind != GATE_NONE) begin
      assert_target_exists_R8: assert ($countones(hit_t) == 1)
        else $error("gate target outside working vector");
    end
  end

endmodule

// File: rtl/rinc_stepper.sv
module rinc_stepper #(
  parameter int STEPW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [STEPW-1:0] step
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step <= '0;
    else if (clear)   step <= '0;
    else if (advance) step <= step + 1'b1;
  end

endmodule

// File: rtl/carry_ancilla_incr.sv
module carry_ancilla_incr
  import rinc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [WIDTH-1:0]   in_value,
  input  logic               in_keep_clean,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WIDTH-1:0]   out_value,
  output logic [WIDTH-2:0]   out_carries,
  output logic               out_clean
);

  localparam int CARRIES = WIDTH - 1;
  localparam int SBITS   = WIDTH + CARRIES;
  localparam int STEPW   = $clog2(3 * WIDTH);
  localparam int LEN_CLR = 3 * WIDTH - 2;
  localparam int LEN_KEEP = 2 * WIDTH;

  seq_state_e       fsm_q;
  logic [SBITS-1:0] work_q;
  logic [SBITS-1:0] work_nxt;
  logic             mode_q;
  logic [STEPW-1:0] step;
  gate_op_t         op;
  logic             last;
  logic             running;
  logic             take;

  assign running  = (fsm_q == SEQ_RUN);
  assign in_ready = (fsm_q == SEQ_IDLE);
  assign take     = in_valid & in_ready;

  rinc_stepper #(.STEPW(STEPW)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (in_ready),
    .advance (running),
    .step    (step)
  );

  rinc_schedule #(.WIDTH(WIDTH), .STEPW(STEPW)) u_sched (
    .step       (step),
    .keep_clean (mode_q),
    .active     (running),
    .op         (op),
    .last       (last)
  );

  rinc_gate #(.SBITS(SBITS)) u_gate (
    .apply (running),
    .op    (op),
    .cur   (work_q),
    .nxt   (work_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= SEQ_IDLE;
      work_q <= '0;
      mode_q <= 1'b0;
    end else begin
      unique case (fsm_q)
        SEQ_IDLE: if (in_valid) begin
          work_q <= {{CARRIES{1'b0}}, in_value};
          mode_q <= in_keep_clean;
          fsm_q  <= SEQ_RUN;
        end
        SEQ_RUN: begin
          work_q <= work_nxt;
          if (last) fsm_q <= SEQ_HOLD;
        end
        SEQ_HOLD: if (out_ready) fsm_q <= SEQ_IDLE;
        default: fsm_q <= SEQ_IDLE;
      endcase
    end
  end

  assign out_valid   = (fsm_q == SEQ_HOLD);
  assign out_value   = work_q[WIDTH-1:0];
  assign out_carries = work_q[SBITS-1:WIDTH];
  assign out_clean   = ~|out_carries;

  // ---------------- assertions ----------------
  logic [WIDTH-1:0] chk_word;
  logic [STEPW-1:0] chk_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_word <= '0;
      chk_lat  <= '0;
    end else if (take) begin
      chk_word <= in_value;
      chk_lat  <= '0;
    end else if (running) begin
      chk_lat  <= chk_lat + 1'b1;
    end
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !in_ready);

  assert_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_value == WIDTH'(chk_word + 1'b1));

  assert_clean_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q) |-> out_clean);

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> chk_lat == (mode_q ? STEPW'(LEN_CLR) : STEPW'(LEN_KEEP)));

  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) && $stable(out_carries)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

endmodule

// File: tb/carry_ancilla_incr_test.sv
module carry_ancilla_incr_test;

  localparam int N = 4;
  localparam int C = N - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] in_value = '0;
  logic         in_keep_clean = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [N-1:0] out_value;
  logic [C-1:0] out_carries;
  logic         out_clean;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  carry_ancilla_incr #(.WIDTH(N)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_value(in_value),
    .in_keep_clean(in_keep_clean),
    .out_valid(out_valid), .out_ready(out_ready), .out_value(out_value),
    .out_carries(out_carries), .out_clean(out_clean)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: 0 idle, 1 running, 2 holding result
  int           m_state = 0;
  int           m_cnt = 0;
  logic [N-1:0] m_in = '0;
  logic         m_mode = 1'b0;

  function automatic logic [N-1:0] exp_value(input logic [N-1:0] v);
    return N'(v + 1);
  endfunction

  function automatic logic [C-1:0] exp_carries(input logic [N-1:0] v, input logic mode);
    logic [C-1:0] r = '0;
    logic acc = v[0];
    if (!mode) begin
      for (int k = 1; k < C; k++) begin
        acc = acc & v[k];
        r[k] = acc;
      end
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0;
      m_cnt = 0;
    end else begin
      case (m_state)
        0: if (in_valid) begin
             m_in = in_value;
             m_mode = in_keep_clean;
             m_cnt = in_keep_clean ? (3 * N - 2) : (2 * N);
             m_state = 1;
           end
        1: begin
             m_cnt--;
             if (m_cnt == 0) m_state = 2;
           end
        default: if (out_ready) m_state = 0;
      endcase
    end
  end

  always @(posedge clk) cyc++;

  // per-cycle comparison against the model
  logic [N+C-1:0] prev_vec = '0;
  bit prev_busy = 0;
  bit prev_hold = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(in_ready == (m_state == 0), "R1 in_ready", in_ready, m_state == 0);
      check(out_valid == (m_state == 2), prev_hold ? "R7 out_valid held" : "R6 out_valid timing",
            out_valid, m_state == 2);
      if (m_state == 2 && out_valid) begin
        check(out_value == exp_value(m_in),
              (m_in == '1) ? "R3 wrap" : (prev_hold ? "R7 held value" : "R2 value"),
              out_value, exp_value(m_in));
        check(out_carries == exp_carries(m_in, m_mode), m_mode ? "R4 carries" : "R5 carries",
              out_carries, exp_carries(m_in, m_mode));
        check(out_clean == (exp_carries(m_in, m_mode) == '0), m_mode ? "R4 clean" : "R5 clean",
              out_clean, exp_carries(m_in, m_mode) == '0);
      end
      if (m_state == 1 && prev_busy)
        check($countones({out_carries, out_value} ^ prev_vec) <= 1, "R8 one bit per step",
              {out_carries, out_value} ^ prev_vec, 0);
      prev_busy = (m_state == 1);
      prev_hold = (m_state == 2) && !out_ready;
      prev_vec = {out_carries, out_value};
    end
  end

  // irregular consumer stalls
  always @(negedge clk) begin
    #1;
    out_ready = ((cyc % 5) != 0) && ((cyc % 7) != 3) && ((cyc % 11) != 4);
  end

  task automatic send(input int v, input logic mode);
    bit took;
    @(negedge clk);
    #1;
    in_valid = 1'b1;
    in_value = N'(v);
    in_keep_clean = mode;
    took = in_ready;
    @(posedge clk);
    while (!took) begin
      @(negedge clk);
      took = in_ready;
      @(posedge clk);
    end
    // R1: offers made while busy must be ignored
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      #1;
      in_value = ~N'(v);
      in_keep_clean = ~mode;
    end
    @(negedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic summary;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    check(out_value == '0, "R9 out_value", out_value, 0);
    check(out_carries == '0, "R9 out_carries", out_carries, 0);
    #1 rst_n = 1'b1;
    for (int m = 1; m >= 0; m--)
      for (int v = 0; v < (1 << N); v++)
        send(v, m[0]);
    send(7, 1'b1);
    send(7, 1'b0);
    send((1 << N) - 1, 1'b0);
    repeat (60) @(negedge clk);
    summary();
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      summary();
    end
  end

endmodule